// File: doc/BRIEF.md
# Thirty-Two Line GPIO Bank with Interrupt Cause Logic

This block is a bank of general-purpose I/O lines behind a small memory-mapped 32-bit register port. Software selects each line's direction, the value it drives, whether its input sense is inverted, and whether an output line follows an externally generated blink waveform instead of its data bit. Two blink waveforms enter as plain inputs. A per-line select bit picks which of the two a line follows.

Every line feeds a two-flop synchronizer. An optional inversion is applied after it, which gives the polarity-adjusted input value. That value feeds two interrupt paths. The level path passes it through a level mask. The edge path latches each 0-to-1 transition into a sticky cause bit, which then passes through an edge mask. With the inversion, one mechanism serves rising, falling, active-high and active-low sense. Software clears cause bits by writing 0 to them. The masked causes are ORed in groups of eight lines into four summary interrupt outputs.

The register file decodes a 4-bit word index with an enumerated type: output data (byte offset 0x00), direction (0x04), blink enable (0x08), input polarity (0x0C), polarity-adjusted input (0x10, read-only), edge cause (0x14), edge mask (0x18), level mask (0x1C) and blink set select (0x20). Accesses whose two low address bits are not zero are ignored.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the edge cause, edge mask and level mask registers read 0x00000000, the output data register reads 0x00000000, the direction register reads 0xFFFFFFFF, and every summary interrupt output is low.
- R2: Direction bit 1 makes the line an input and holds its `pin_oe` bit at 0. Direction bit 0 sets `pin_oe` to 1. While blink is disabled, `pin_out` follows the output data register one cycle after the write.
- R3: The register at 0x10 returns the pin value after a two-flop synchronizer, XORed with the polarity register. A pin change first shows there after two rising clock edges. Writes to 0x10 have no effect.
- R4: A 0-to-1 change of a polarity-adjusted input bit sets the matching edge cause bit. The bit stays set until software clears it. With polarity 1, only a falling pin edge sets the cause.
- R5: A write to the edge cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R7: Line cause equals (input AND level mask) OR (edge cause AND edge mask). `irq_group[g]` is the OR of the line causes for lines 8g to 8g+7.
- R8: When a line's blink enable bit is 1, `pin_out` carries `blink_a` if that line's select bit is 0 and `blink_b` if it is 1. When the enable bit is 0, `pin_out` carries the output data bit.
- R9: Every read/write register returns the last value written. Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.
- R10: With level mask set and polarity 0, the line interrupts while the pin is high. With polarity 1, it interrupts while the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Value driven to pins |
| pin_oe | output | 32 | Pin output enable, 1 = drive |
| blink_a | input | 1 | Blink waveform, set A |
| blink_b | input | 1 | Blink waveform, set B |
| irq_group | output | 4 | Summary interrupts, one per eight lines |

## Verification
The interaction that needs care is a software clear of the edge cause register landing in the same cycle that the edge detector reports a new transition on the same bit. The bench causes this by changing a pin at a known falling clock edge. It counts the two synchronizer edges and issues the all-zero clear write so that it is sampled on the third rising edge, which is the cycle in which the edge pulse is high. A later read must still show that bit set. A clear issued in a quiet cycle must empty the register. Side effects of polarity changes are handled the same way: a polarity change creates an edge of its own, so the bench clears the resulting cause before it judges the next stimulus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_ADDR_W = 6;
    localparam int REG_IDX_W   = BANK_ADDR_W - 2;

    // Word index of each register; the index sets the software-visible offset.
    typedef enum logic [REG_IDX_W-1:0] {
        RI_DOUT   = 4'd0,
        RI_DIR    = 4'd1,
        RI_BLINK  = 4'd2,
        RI_POL    = 4'd3,
        RI_DIN    = 4'd4,
        RI_ECAUSE = 4'd5,
        RI_EMASK  = 4'd6,
        RI_LMASK  = 4'd7,
        RI_BSEL   = 4'd8
    } reg_idx_e;

endpackage

// File: rtl/gpio_line_sense.sv
module gpio_line_sense #(
    parameter int LINES       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    input  logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] data_in,
    output logic [LINES-1:0] edge_evt
);

    logic [SYNC_STAGES-1:0][LINES-1:0] sync_q;
    logic [LINES-1:0]                  prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
            prev_q <= data_in;
        end
    end

    // Polarity is applied after the synchronizer, so it affects both interrupt paths.
    assign data_in  = sync_q[SYNC_STAGES-1] ^ pol_q;
    assign edge_evt = data_in & ~prev_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int               LINES   = 32,
    parameter logic [LINES-1:0] DIR_RST = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [BANK_ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]       bus_wdata,
    output logic [LINES-1:0]       bus_rdata,
    input  logic [LINES-1:0]       data_in,
    input  logic [LINES-1:0]       edge_evt,
    output logic [LINES-1:0]       dout_q,
    output logic [LINES-1:0]       dir_q,
    output logic [LINES-1:0]       blink_q,
    output logic [LINES-1:0]       pol_q,
    output logic [LINES-1:0]       ecause_q,
    output logic [LINES-1:0]       emask_q,
    output logic [LINES-1:0]       lmask_q,
    output logic [LINES-1:0]       bsel_q
);

    reg_idx_e         idx;
    logic             aligned;
    logic             wr_hit;
    logic             rd_hit;
    logic [LINES-1:0] keep_mask;
    logic [LINES-1:0] rd_mux;

    assign idx     = reg_idx_e'(bus_addr[BANK_ADDR_W-1:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_valid && bus_write && aligned;
    assign rd_hit  = bus_valid && !bus_write && aligned;

    // A zero written to a cause bit clears it; ones keep it unchanged.
    assign keep_mask = (wr_hit && idx == RI_ECAUSE) ? bus_wdata : '1;

    always_comb begin
        case (idx)
            RI_DOUT:   rd_mux = dout_q;
            RI_DIR:    rd_mux = dir_q;
            RI_BLINK:  rd_mux = blink_q;
            RI_POL:    rd_mux = pol_q;
            RI_DIN:    rd_mux = data_in;
            RI_ECAUSE: rd_mux = ecause_q;
            RI_EMASK:  rd_mux = emask_q;
            RI_LMASK:  rd_mux = lmask_q;
            RI_BSEL:   rd_mux = bsel_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= DIR_RST;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
            bsel_q  <= '0;
        end else if (wr_hit) begin
            case (idx)
                RI_DOUT:  dout_q  <= bus_wdata;
                RI_DIR:   dir_q   <= bus_wdata;
                RI_BLINK: blink_q <= bus_wdata;
                RI_POL:   pol_q   <= bus_wdata;
                RI_EMASK: emask_q <= bus_wdata;
                RI_LMASK: lmask_q <= bus_wdata;
                RI_BSEL:  bsel_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // A new edge is ORed in after the clear, so it wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecause_q <= '0;
        end else begin
            ecause_q <= (ecause_q & keep_mask) | edge_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_hit) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int LINES = 32
) (
    input  logic [LINES-1:0] dout_q,
    input  logic [LINES-1:0] dir_q,
    input  logic [LINES-1:0] blink_q,
    input  logic [LINES-1:0] bsel_q,
    input  logic             blink_a,
    input  logic             blink_b,
    output logic [LINES-1:0] pin_out,
    output logic [LINES-1:0] pin_oe
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic wave;
        assign wave       = bsel_q[i] ? blink_b : blink_a;
        assign pin_out[i] = blink_q[i] ? wave : dout_q[i];
        assign pin_oe[i]  = ~dir_q[i];
    end

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int LINES = 32,
    parameter int GROUP = 8,
    localparam int NGROUP = LINES / GROUP
) (
    input  logic [LINES-1:0]  data_in,
    input  logic [LINES-1:0]  ecause_q,
    input  logic [LINES-1:0]  emask_q,
    input  logic [LINES-1:0]  lmask_q,
    output logic [NGROUP-1:0] irq_group
);

    logic [LINES-1:0] line_cause;

    assign line_cause = (data_in & lmask_q) | (ecause_q & emask_q);

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign irq_group[g] = |line_cause[g*GROUP +: GROUP];
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int LINES       = 32,
    parameter int GROUP       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NGROUP     = LINES / GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [BANK_ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]       bus_wdata,
    output logic [LINES-1:0]       bus_rdata,
    input  logic [LINES-1:0]       pin_in,
    output logic [LINES-1:0]       pin_out,
    output logic [LINES-1:0]       pin_oe,
    input  logic                   blink_a,
    input  logic                   blink_b,
    output logic [NGROUP-1:0]      irq_group
);

    logic [LINES-1:0] data_in;
    logic [LINES-1:0] edge_evt;
    logic [LINES-1:0] dout_q;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] blink_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] ecause_q;
    logic [LINES-1:0] emask_q;
    logic [LINES-1:0] lmask_q;
    logic [LINES-1:0] bsel_q;

    gpio_line_sense #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pol_q    (pol_q),
        .data_in  (data_in),
        .edge_evt (edge_evt)
    );

    gpio_bank_regs #(.LINES(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .data_in   (data_in),
        .edge_evt  (edge_evt),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .blink_q   (blink_q),
        .pol_q     (pol_q),
        .ecause_q  (ecause_q),
        .emask_q   (emask_q),
        .lmask_q   (lmask_q),
        .bsel_q    (bsel_q)
    );

    gpio_pin_drive #(.LINES(LINES)) u_drive (
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .blink_q (blink_q),
        .bsel_q  (bsel_q),
        .blink_a (blink_a),
        .blink_b (blink_b),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    gpio_irq_group #(.LINES(LINES), .GROUP(GROUP)) u_irq (
        .data_in   (data_in),
        .ecause_q  (ecause_q),
        .emask_q   (emask_q),
        .lmask_q   (lmask_q),
        .irq_group (irq_group)
    );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int NGROUP = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [BANK_ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]       bus_wdata,
    input logic [LINES-1:0]       bus_rdata,
    input logic [LINES-1:0]       edge_evt,
    input logic [LINES-1:0]       ecause,
    input logic [LINES-1:0]       emask,
    input logic [LINES-1:0]       lmask,
    input logic [NGROUP-1:0]      irq_group
);

    logic cause_wr;
    assign cause_wr = bus_valid && bus_write && (bus_addr == BANK_ADDR_W'(8'h14));

    p_cause_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((ecause & $past(ecause)) == $past(ecause)));

    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && bus_wdata == '0 && edge_evt == '0) |=> (ecause == '0));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((ecause & $past(edge_evt)) == $past(edge_evt)));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (emask == '0 && lmask == '0) |-> (irq_group == '0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.LINES(LINES), .NGROUP(NGROUP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .edge_evt  (edge_evt),
    .ecause    (ecause_q),
    .emask     (emask_q),
    .lmask     (lmask_q),
    .irq_group (irq_group)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_DOUT   = 6'h00;
    localparam logic [5:0] A_DIR    = 6'h04;
    localparam logic [5:0] A_BLINK  = 6'h08;
    localparam logic [5:0] A_POL    = 6'h0C;
    localparam logic [5:0] A_DIN    = 6'h10;
    localparam logic [5:0] A_ECAUSE = 6'h14;
    localparam logic [5:0] A_EMASK  = 6'h18;
    localparam logic [5:0] A_LMASK  = 6'h1C;
    localparam logic [5:0] A_BSEL   = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        blink_a = 1'b0;
    logic        blink_b = 1'b0;
    logic [3:0]  irq_group;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .blink_a   (blink_a),
        .blink_b   (blink_b),
        .irq_group (irq_group)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Driver side of the scoreboard: queue the expected value, then issue the read.
    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor side: a read seen at a rising edge is compared at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_valid && !bus_write) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset values
        chk({28'd0, irq_group}, 32'h0, "R1 irq after reset");
        rd(A_ECAUSE, 32'h0, "R1 edge cause reset");
        rd(A_EMASK,  32'h0, "R1 edge mask reset");
        rd(A_LMASK,  32'h0, "R1 level mask reset");
        rd(A_DIR,    32'hFFFF_FFFF, "R1 direction reset");
        rd(A_DOUT,   32'h0, "R1 output reset");
        chk(pin_oe, 32'h0, "R1 no pin driven after reset");

        // R9 register readback
        wr(A_DOUT, 32'hA5A5_0F0F);
        wr(A_DIR,  32'hFFFF_0000);
        wr(A_BSEL, 32'h0000_00F0);
        wr(A_EMASK, 32'h1234_5678);
        wr(A_LMASK, 32'h8765_4321);
        rd(A_DOUT,  32'hA5A5_0F0F, "R9 output readback");
        rd(A_DIR,   32'hFFFF_0000, "R9 direction readback");
        rd(A_BSEL,  32'h0000_00F0, "R9 select readback");
        rd(A_EMASK, 32'h1234_5678, "R9 edge mask readback");
        rd(A_LMASK, 32'h8765_4321, "R9 level mask readback");
        wr(A_EMASK, 32'h0);
        wr(A_LMASK, 32'h0);

        // R3 data-in is read-only
        wr(A_DIN, 32'hFFFF_FFFF);
        rd(A_DIN, 32'h0, "R3 write to data-in ignored");

        // R2 direction and output data
        chk(pin_oe,  32'h0000_FFFF, "R2 output enables");
        chk(pin_out, 32'hA5A5_0F0F, "R2 pin value from output register");

        // R3 and R4 rising edge with polarity 0
        @(negedge clk); pin_in = 32'h0001_0000;
        cyc(4);
        rd(A_DIN,    32'h0001_0000, "R3 synchronized data-in");
        rd(A_ECAUSE, 32'h0001_0000, "R4 rising edge latched");
        cyc(3);
        rd(A_ECAUSE, 32'h0001_0000, "R4 cause held");

        // R5 write-zero-to-clear
        wr(A_ECAUSE, 32'hFFFF_FFFF);
        rd(A_ECAUSE, 32'h0001_0000, "R5 ones leave cause unchanged");
        wr(A_ECAUSE, 32'hFFFE_FFFF);
        rd(A_ECAUSE, 32'h0, "R5 zero clears cause");

        // R4 falling sense with polarity 1 on line 17
        wr(A_POL, 32'h0002_0000);
        cyc(3);
        wr(A_ECAUSE, 32'h0);
        rd(A_ECAUSE, 32'h0, "R5 clear after polarity change");
        @(negedge clk); pin_in = 32'h0003_0000;
        cyc(4);
        rd(A_ECAUSE, 32'h0, "R4 rising pin ignored under inversion");
        rd(A_DIN, 32'h0001_0000, "R3 polarity applied to data-in");
        @(negedge clk); pin_in = 32'h0001_0000;
        cyc(4);
        rd(A_ECAUSE, 32'h0002_0000, "R4 falling pin latched under inversion");

        // R7 edge mask gating and grouping (line 17 -> group 2)
        chk({28'd0, irq_group}, 32'h0, "R7 masked cause gives no irq");
        wr(A_EMASK, 32'h0002_0000);
        chk({28'd0, irq_group}, 32'h4, "R7 unmasked edge cause on group 2");
        wr(A_ECAUSE, 32'h0);
        chk({28'd0, irq_group}, 32'h0, "R7 irq drops after clear");

        // R10 level sense on line 24 (group 3)
        wr(A_LMASK, 32'h0100_0000);
        chk({28'd0, irq_group}, 32'h0, "R10 level low, no irq");
        @(negedge clk); pin_in = 32'h0101_0000;
        cyc(3);
        chk({28'd0, irq_group}, 32'h8, "R10 active-high level irq");
        wr(A_POL, 32'h0102_0000);
        chk({28'd0, irq_group}, 32'h0, "R10 inverted, high pin quiet");
        @(negedge clk); pin_in = 32'h0001_0000;
        cyc(3);
        chk({28'd0, irq_group}, 32'h8, "R10 active-low level irq");
        wr(A_LMASK, 32'h0);
        cyc(2);
        wr(A_ECAUSE, 32'h0);
        rd(A_ECAUSE, 32'h0, "R5 cleared before collision test");

        // R6 edge on line 8 collides with an all-zero clear
        @(negedge clk); pin_in = 32'h0001_0100;
        @(negedge clk);
        wr(A_ECAUSE, 32'h0);
        rd(A_ECAUSE, 32'h0000_0100, "R6 set wins over same-cycle clear");
        wr(A_ECAUSE, 32'h0);
        rd(A_ECAUSE, 32'h0, "R6 later clear succeeds");

        // R8 blink on line 0 (set A) and line 4 (set B)
        wr(A_BLINK, 32'h0000_0011);
        @(negedge clk); blink_a = 1'b0; blink_b = 1'b1;
        #1 chk(pin_out, 32'hA5A5_0F1E, "R8 blink a=0 b=1");
        @(negedge clk); blink_a = 1'b1; blink_b = 1'b0;
        #1 chk(pin_out, 32'hA5A5_0F0F, "R8 blink a=1 b=0");
        @(negedge clk); blink_a = 1'b0; blink_b = 1'b1;
        wr(A_BLINK, 32'h0);
        chk(pin_out, 32'hA5A5_0F0F, "R8 blink disabled uses output data");

        // R2 output update
        wr(A_DOUT, 32'h0000_00F0);
        chk(pin_out, 32'h0000_00F0, "R2 pin follows new output data");

        cyc(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9 reads outstanding actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule